// File: doc/BRIEF.md
# Debug Breakpoint Address Comparator

This block watches the stream of retiring instructions and raises a breakpoint event when an instruction falls on one programmed code location. The location is a word address plus a 4-bit select mask. The mask marks which of the two halfwords in that word count. The comparator understands two instruction-set states. The first is a fixed-width state, where every instruction is 32 bits and word aligned. The second is a mixed state, where instructions are 16 or 32 bits wide and halfword aligned, so a 32-bit instruction may cross a word boundary.

Several cases have no single architectural answer, and the block settles them in fixed ways. An all-zero mask leaves the comparator disabled. A hit that touches only the second halfword of a 32-bit instruction counts only while the illegal-execution-state flag is clear. A link to a context comparator that is absent, or that cannot match context, suppresses the event altogether. The link-number read-back shows all ones while such a link is programmed.

A debug unit would instantiate one comparator per breakpoint slot. It feeds each slot the retire strobe, the retire address and the per-slot hit bits of the context comparators. The result is a registered pulse that lasts one cycle.

Top module: `bp_addr_match`

## Requirements
- R1: The retire address is compared with the programmed address on bits [ADDR_W-1:2] only. Bits [1:0] of the programmed address are ignored. An instruction that covers no halfword of the programmed word never hits.
- R2: Mask bits [1:0] select the low halfword (byte offset 0) and mask bits [3:2] select the high halfword (byte offset 2). A halfword counts only when both of its mask bits are set, so a mask with one bit of a pair set does not select that halfword.
- R3: A mask of 0000 never produces an event, whatever the other inputs are.
- R4: In the fixed-width state (isaMixed=0), retireAddr[1:0] and instWide are ignored, and the instruction covers both halfwords of its word. Mask 1111 or 0011 hits. Mask 1100 hits only when illegalState=0.
- R5: In the mixed state (isaMixed=1) a 16-bit instruction (instWide=0) at halfword offset retireAddr[1] hits when that halfword is selected, and never depends on illegalState.
- R6: In the mixed state, a 32-bit instruction at the programmed word plus 2 hits with mask 1111 (or 1100), whatever the value of illegalState.
- R7: When the only selected halfword an instruction covers is its second halfword, the event is raised if illegalState=0 and suppressed if illegalState=1. This includes a mixed 32-bit instruction at the programmed word minus 2, whose second halfword is the low halfword of the programmed word.
- R8: With linkEn=1 and a linkIdx that is NUM_CTX or larger, or whose bit in CTX_AWARE is 0, no event is produced and linkIdxRd reads all ones. Otherwise linkIdxRd equals linkIdx.
- R9: With linkEn=1 and a valid, context-aware linkIdx, an address hit produces an event only when ctxHits[linkIdx] is 1. With linkEn=0, ctxHits has no effect.
- R10: bpEvent is registered. It is high in exactly the cycle after a qualifying retireValid cycle and low after any cycle without retireValid.
- R11: With enable=0 in a retire cycle, no event follows.
- R12: While rstN is low, and after reset, bpEvent is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Comparator enable |
| selMask | input | 4 | Halfword select mask |
| bpAddr | input | ADDR_W | Programmed breakpoint address |
| linkEn | input | 1 | Require a linked context comparator |
| linkIdx | input | LINK_W | Index of the linked context comparator |
| ctxHits | input | NUM_CTX | Per-index hit bits from the context comparators |
| retireValid | input | 1 | One instruction retires this cycle |
| retireAddr | input | ADDR_W | Address of the retiring instruction |
| isaMixed | input | 1 | 0 = fixed-width 32-bit state, 1 = mixed 16/32-bit state |
| instWide | input | 1 | In the mixed state: 1 = 32-bit instruction, 0 = 16-bit |
| illegalState | input | 1 | Illegal-execution-state flag |
| linkIdxRd | output | LINK_W | Read-back of the link number |
| bpEvent | output | 1 | Breakpoint event pulse |

## Verification
The event for a retire is due one clock later. The bench drives inputs at the falling edge, the rising edge captures them, and the bench reads bpEvent at the next falling edge. At that point it compares the value with the one its reference model predicted for the cycle before. Each retire is followed by an idle cycle, so a pulse that lasts too long shows up as a mismatch. The link read-back is combinational, so the bench checks it within the same cycle, shortly after it drives the link inputs.

// File: rtl/bp_match_pkg.sv
package bp_match_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic armed;        // retire, enabled, link condition met
    logic allowSecond;  // a hit on the second halfword alone may fire
  } bpStrobe_t;

  localparam int SEL_W       = 4;
  localparam int HW_PER_WORD = 2;

endpackage

// File: rtl/bp_match_ctrl.sv
module bp_match_ctrl
  import bp_match_pkg::*;
#(
  parameter int LINK_W = 4,
  parameter int NUM_CTX = 6,
  parameter logic [NUM_CTX-1:0] CTX_AWARE = '1
) (
  input  logic               enable,
  input  logic               retireValid,
  input  logic               illegalState,
  input  logic               linkEn,
  input  logic [LINK_W-1:0]  linkIdx,
  input  logic [NUM_CTX-1:0] ctxHits,
  output bpStrobe_t          strobes,
  output logic [LINK_W-1:0]  linkIdxRd
);

  logic linkExists;
  logic linkAware;
  logic linkCtxHit;
  logic badLink;
  logic linkOk;

  // Find the linked comparator: absent, context-aware, and its hit bit
  always_comb begin
    linkExists = 1'b0;
    linkAware  = 1'b0;
    linkCtxHit = 1'b0;
    for (int i = 0; i < NUM_CTX; i++) begin
      if (linkIdx == LINK_W'(i)) begin
        linkExists = 1'b1;
        linkAware  = CTX_AWARE[i];
        linkCtxHit = ctxHits[i];
      end
    end
  end

  assign badLink = linkEn & ~(linkExists & linkAware);
  assign linkOk  = ~linkEn | (linkExists & linkAware & linkCtxHit);

  // A broken link reads back as a fixed all-ones value
  assign linkIdxRd = badLink ? {LINK_W{1'b1}} : linkIdx;

  assign strobes.armed       = enable & retireValid & linkOk;
  assign strobes.allowSecond = ~illegalState;

endmodule

// File: rtl/bp_match_datapath.sv
module bp_match_datapath
  import bp_match_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  bpStrobe_t         strobes,
  input  logic [SEL_W-1:0]  selMask,
  input  logic [ADDR_W-1:0] bpAddr,
  input  logic [ADDR_W-1:0] retireAddr,
  input  logic              isaMixed,
  input  logic              instWide,
  output logic              bpEvent
);

  localparam int WORD_W = ADDR_W - 2;

  logic [HW_PER_WORD-1:0] hwSel;
  logic [WORD_W-1:0] bpWord;
  logic [WORD_W-1:0] curWord;
  logic [WORD_W-1:0] secWord;
  logic firstOff;
  logic secOff;
  logic isWide;
  logic firstHit;
  logic secondHit;
  logic addrHit;

  // A halfword is selected only when both of its mask bits are set
  for (genvar h = 0; h < HW_PER_WORD; h++) begin : g_hwSel
    assign hwSel[h] = &selMask[2*h+1 -: 2];
  end

  assign bpWord  = bpAddr[ADDR_W-1:2];
  assign curWord = retireAddr[ADDR_W-1:2];

  // Fixed-width instructions are always word aligned
  assign firstOff = isaMixed & retireAddr[1];
  assign isWide   = ~isaMixed | instWide;

  // The second halfword may spill into the next word
  assign secOff  = ~firstOff;
  assign secWord = firstOff ? curWord + WORD_W'(1) : curWord;

  assign firstHit  = (curWord == bpWord) & hwSel[firstOff];
  assign secondHit = isWide & (secWord == bpWord) & hwSel[secOff];
  assign addrHit   = firstHit | (secondHit & strobes.allowSecond);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bpEvent <= 1'b0;
    else       bpEvent <= strobes.armed & addrHit;
  end

endmodule

// File: rtl/bp_addr_match.sv
module bp_addr_match
  import bp_match_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINK_W = 4,
  parameter int NUM_CTX = 6,
  parameter logic [NUM_CTX-1:0] CTX_AWARE = 6'b101101
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [3:0]         selMask,
  input  logic [ADDR_W-1:0]  bpAddr,
  input  logic               linkEn,
  input  logic [LINK_W-1:0]  linkIdx,
  input  logic [NUM_CTX-1:0] ctxHits,
  input  logic               retireValid,
  input  logic [ADDR_W-1:0]  retireAddr,
  input  logic               isaMixed,
  input  logic               instWide,
  input  logic               illegalState,
  output logic [LINK_W-1:0]  linkIdxRd,
  output logic               bpEvent
);

  bpStrobe_t strobes;

  bp_match_ctrl #(
    .LINK_W(LINK_W), .NUM_CTX(NUM_CTX), .CTX_AWARE(CTX_AWARE)
  ) u_ctrl (
    .enable(enable), .retireValid(retireValid), .illegalState(illegalState),
    .linkEn(linkEn), .linkIdx(linkIdx), .ctxHits(ctxHits),
    .strobes(strobes), .linkIdxRd(linkIdxRd)
  );

  bp_match_datapath #(
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .selMask(selMask),
    .bpAddr(bpAddr), .retireAddr(retireAddr), .isaMixed(isaMixed),
    .instWide(instWide), .bpEvent(bpEvent)
  );

endmodule

// File: rtl/bp_match_checker.sv
module bp_match_checker #(
  parameter int ADDR_W = 32,
  parameter int LINK_W = 4,
  parameter int NUM_CTX = 6,
  parameter logic [NUM_CTX-1:0] CTX_AWARE = 6'b101101
) (
  input logic               clk,
  input logic               rstN,
  input logic               enable,
  input logic [3:0]         selMask,
  input logic               linkEn,
  input logic [LINK_W-1:0]  linkIdx,
  input logic               retireValid,
  input logic [LINK_W-1:0]  linkIdxRd,
  input logic               bpEvent
);

  logic seen;
  logic linkBad;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seen <= 1'b0;
    else       seen <= 1'b1;
  end

  always_comb begin
    linkBad = linkEn;
    for (int i = 0; i < NUM_CTX; i++)
      if (linkIdx == LINK_W'(i) && CTX_AWARE[i]) linkBad = 1'b0;
  end

  AST_RESET_LOW: assert property (@(posedge clk) !rstN |-> !bpEvent); // R12
  AST_ZERO_SEL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    seen && $past(selMask == 4'b0000) |-> !bpEvent); // R3
  AST_BAD_LINK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    seen && $past(linkBad) |-> !bpEvent); // R8
  AST_BAD_LINK_READ: assert property (@(posedge clk) disable iff (!rstN)
    linkBad |-> (linkIdxRd == {LINK_W{1'b1}})); // R8
  AST_GOOD_LINK_READ: assert property (@(posedge clk) disable iff (!rstN)
    !linkBad |-> (linkIdxRd == linkIdx)); // R8
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    seen && $past(!enable) |-> !bpEvent); // R11
  AST_NEEDS_RETIRE: assert property (@(posedge clk) disable iff (!rstN)
    seen && bpEvent |-> $past(retireValid)); // R10

endmodule

bind bp_addr_match bp_match_checker #(
  .ADDR_W(ADDR_W), .LINK_W(LINK_W), .NUM_CTX(NUM_CTX), .CTX_AWARE(CTX_AWARE)
) u_chk (.*);

// File: tb/test_bp_addr_match.sv
module test_bp_addr_match;

  localparam int ADDR_W = 32;
  localparam int LINK_W = 4;
  localparam int NUM_CTX = 6;
  localparam logic [NUM_CTX-1:0] CTX_AWARE = 6'b101101;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [3:0] selMask = 4'b0;
  logic [ADDR_W-1:0] bpAddr = 32'h0000_1230;
  logic linkEn = 1'b0;
  logic [LINK_W-1:0] linkIdx = '0;
  logic [NUM_CTX-1:0] ctxHits = '0;
  logic retireValid = 1'b0;
  logic [ADDR_W-1:0] retireAddr = '0;
  logic isaMixed = 1'b0;
  logic instWide = 1'b0;
  logic illegalState = 1'b0;
  logic [LINK_W-1:0] linkIdxRd;
  logic bpEvent;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bp_addr_match #(
    .ADDR_W(ADDR_W), .LINK_W(LINK_W), .NUM_CTX(NUM_CTX), .CTX_AWARE(CTX_AWARE)
  ) i_bp_addr_match (
    .clk(clk), .rstN(rstN), .enable(enable), .selMask(selMask), .bpAddr(bpAddr),
    .linkEn(linkEn), .linkIdx(linkIdx), .ctxHits(ctxHits),
    .retireValid(retireValid), .retireAddr(retireAddr), .isaMixed(isaMixed),
    .instWide(instWide), .illegalState(illegalState),
    .linkIdxRd(linkIdxRd), .bpEvent(bpEvent)
  );

  // Is the halfword at byte address a covered by the mask?
  function automatic bit hwPicked(logic [31:0] a);
    int k;
    if ((a >> 2) != (bpAddr >> 2)) return 0;
    k = int'((a >> 1) & 1);
    return selMask[2*k] && selMask[2*k+1];
  endfunction

  function automatic bit refEvent();
    logic [31:0] first;
    bit wide, h1, h2;
    if (!enable || !retireValid) return 0;
    if (linkEn) begin
      if (linkIdx >= NUM_CTX) return 0;
      if (!CTX_AWARE[linkIdx]) return 0;
      if (!ctxHits[linkIdx]) return 0;
    end
    first = isaMixed ? (retireAddr & ~32'h1) : (retireAddr & ~32'h3);
    wide  = !isaMixed || instWide;
    h1 = hwPicked(first);
    h2 = wide && hwPicked(first + 32'd2);
    return h1 || (h2 && !illegalState);
  endfunction

  bit expQ[$];
  string tagQ[$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (sel=%b mixed=%b wide=%b ill=%b addr=%h)",
               tag, act, exp, selMask, isaMixed, instWide, illegalState, retireAddr);
    end
  endtask

  // Inputs were set right after a falling edge; check one cycle later
  task automatic runCycle(string tag);
    logic [LINK_W-1:0] rdExp;
    #1;
    rdExp = (linkEn && (linkIdx >= NUM_CTX || !CTX_AWARE[linkIdx])) ? '1 : linkIdx;
    if (linkEn) check({tag, " readback R8"}, 32'(linkIdxRd), 32'(rdExp));
    expQ.push_back(refEvent());
    tagQ.push_back(tag);
    @(negedge clk);
    check(tagQ.pop_front(), 32'(bpEvent), 32'(expQ.pop_front()));
  endtask

  task automatic retire(string tag, logic [31:0] addr);
    retireValid = 1'b1;
    retireAddr = addr;
    runCycle(tag);
    retireValid = 1'b0;
    retireAddr = 32'hdead_beec;
    runCycle("R10 idle");
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      finishRun();
    end
  end

  initial begin
    string tag;
    enable = 1'b1;
    selMask = 4'b1111;
    retireValid = 1'b1;
    retireAddr = bpAddr;
    repeat (3) @(negedge clk);
    check("R12 reset", 32'(bpEvent), 32'd0);
    rstN = 1'b1;
    retireValid = 1'b0;
    runCycle("R12 after reset");

    // Full sweep of mask, state, width, flag and offset
    for (int s = 0; s < 16; s++)
      for (int m = 0; m < 2; m++)
        for (int w = 0; w < 2; w++)
          for (int il = 0; il < 2; il++)
            for (int off = 0; off < 2; off++) begin
              selMask = 4'(s);
              isaMixed = 1'(m);
              instWide = 1'(w);
              illegalState = 1'(il);
              if (s == 0) tag = "R3";
              else if (m == 0) tag = "R4";
              else if (w == 0) tag = "R5";
              else if (off == 1) tag = "R6";
              else tag = "R7";
              retire(tag, bpAddr + 32'(off * 2));
            end

    // Straddling instruction ending in the programmed word
    isaMixed = 1'b1; instWide = 1'b1;
    for (int s = 0; s < 16; s++)
      for (int il = 0; il < 2; il++) begin
        selMask = 4'(s);
        illegalState = 1'(il);
        retire("R7 straddle", bpAddr - 32'd2);
      end

    // Neighbouring words and low address bits of the programmed address
    selMask = 4'b1111; illegalState = 1'b0;
    retire("R1 next word", bpAddr + 32'd4);
    retire("R1 prev word", bpAddr - 32'd4);
    isaMixed = 1'b0;
    bpAddr = 32'h0000_1233;
    retire("R1 low bits ignored", 32'h0000_1230);
    bpAddr = 32'h0000_1230;

    // Half-set pairs
    isaMixed = 1'b1; instWide = 1'b0;
    selMask = 4'b0111;
    retire("R2 high pair half set", bpAddr + 32'd2);
    retire("R2 low pair full", bpAddr);
    selMask = 4'b1101;
    retire("R2 low pair half set", bpAddr);

    // Enable off
    selMask = 4'b1111; isaMixed = 1'b0;
    enable = 1'b0;
    retire("R11", bpAddr);
    enable = 1'b1;

    // Back-to-back retires, then idle
    retireValid = 1'b1; retireAddr = bpAddr;
    runCycle("R10 b2b");
    runCycle("R10 b2b");
    retireValid = 1'b0;
    runCycle("R10 drop");

    // Links
    ctxHits = '1;
    linkEn = 1'b1;
    for (int i = 0; i < 16; i++) begin
      linkIdx = 4'(i);
      retire((i >= NUM_CTX || !CTX_AWARE[i]) ? "R8" : "R9", bpAddr);
    end
    linkIdx = 4'd2;
    ctxHits = 6'b111011;
    retire("R9 ctx miss", bpAddr);
    ctxHits = 6'b000100;
    retire("R9 ctx hit", bpAddr);
    linkEn = 1'b0;
    ctxHits = '0;
    retire("R9 unlinked", bpAddr);

    finished = 1;
    finishRun();
  end

endmodule